// File: doc/BRIEF.md
# Matrix Converter Switch-State Sequencer

Once per switching period, this block plays out the on/off pattern of a 4×3 bidirectional switch array. The array links four input lines (three supply phases A, B, C and the supply neutral N) to three output phases a, b and c.

A modulator supplies the block's inputs:
- three rectifier-side vector codes, each with its share of the period;
- the output-side sector;
- the two unscaled active-vector duties of that sector.

The block works out the interval boundaries in clock cycles and walks a cycle counter through them. On each cycle it drives the product of the current rectifier state and the current output-side state as a 12-bit switch word.

Each half-voltage (virtual) rectifier vector has its time split into two halves. The two neutral-arm vectors that surround it each get one half, so the mean neutral current over the period is zero. The output side never applies a zero vector. Its two active duties are rescaled so that together they fill each rectifier interval.

A pulse on `start` loads a new parameter set and restarts the period at cycle 0. Without a new pulse, the loaded sequence repeats every period. A combinational flag reports any output phase that does not have exactly one closed switch.

Top module: `mc_switch_sequencer`

## Requirements
- R1: From reset until the first `start`, `sw` is 12'h111, so every output phase is tied to input A.
- R2: Bit `4*p+i` of `sw` closes the switch from input i (0=A, 1=B, 2=C, 3=N) to output phase p (0=a, 1=b, 2=c). Exactly one bit per phase is set on every cycle.
- R3: With P = CLK_HZ/SW_HZ, the slot lengths are as follows. Slot 0 lasts round(duty0·P/65536) cycles. Slot 1 lasts round(duty1·P/65536) cycles, clipped to what is left of P. Slot 2 takes the remainder. The slots play in the order 0, 1, 2.
- R4: Codes 7–12 are virtual vector k = code−6. The first floor(len/2) cycles use short vector k−1 (k=1 wraps to 6). The rest of the slot uses short vector k. The short vectors, as (positive rail, negative rail), are: 1=(A,N), 2=(N,C), 3=(B,N), 4=(N,A), 5=(C,N), 6=(N,B).
- R5: Codes 1–6 are line vectors for the whole slot: 1=(A,B), 2=(A,C), 3=(B,C), 4=(B,A), 5=(C,A), 6=(C,B). Codes 0 and 13–15 are the null vector (A,A).
- R6: For a sector s in 0–5, the first active vector is g = s+1 and the second is the next one, with 6 followed by 1. Sector values 6 and 7 act as sector 0. The six patterns, listed as the output phases on the positive rail, are: 1={a}, 2={a,b}, 3={b}, 4={b,c}, 5={c}, 6={a,c}. The remaining phases sit on the negative rail.
- R7: The ratio q is floor(duty_g·65536/(duty_g+duty_d)), or 32768 if both duties are zero. A sub-slot of L cycles gives round(L·q/65536) cycles to the first active vector and the rest to the second. No output-side zero vector is ever inserted.
- R8: Sub-slots are numbered j = 0..5, with two per slot; a slot that is not virtual has an empty second sub-slot. Even j plays the first active vector before the second; odd j plays them in the reverse order. Intervals of zero length are skipped.
- R9: A `start` sampled at a clock edge loads all inputs and sets the period cycle to 0. Otherwise the cycle advances by one and wraps from P−1 to 0, so the sequence repeats.
- R10: `phase_fault` is high exactly when some output phase in `sw` has no switch closed or more than one closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the inputs and begin a period |
| vec0 | input | 4 | Rectifier code for slot 0 |
| vec1 | input | 4 | Rectifier code for slot 1 |
| vec2 | input | 4 | Rectifier code for slot 2 |
| duty0 | input | DUTY_W | Slot 0 share of the period, fraction of 65536 |
| duty1 | input | DUTY_W | Slot 1 share of the period, fraction of 65536 |
| inv_sector | input | 3 | Output-side sector, 0–5 |
| duty_g | input | DUTY_W | Unscaled duty of the first active vector |
| duty_d | input | DUTY_W | Unscaled duty of the second active vector |
| sw | output | 12 | Switch word, one bit per switch |
| phase_fault | output | 1 | Output phase without exactly one closed switch |

## Verification
The hardest case to reach is a period whose three slots all hold virtual vectors. That gives up to twelve intervals, with some of them only one or two cycles long or empty after rounding. In that case the alternating first/second order and the half-splits must line up cycle for cycle. The bench builds such periods with unequal duties and lopsided active-vector ratios. It also drives an all-zero active-duty pair, an out-of-range sector and code, and duties that sum to more than one period. Each time it restarts mid-period, and it compares every cycle against a model built only from the stated rounding rules.

// File: rtl/mc_seq_pkg.sv
`timescale 1ns/1ps
package mc_seq_pkg;

    localparam int N_SLOT = 3;
    localparam int N_SUB  = 2 * N_SLOT;
    localparam int N_SEG  = 2 * N_SUB;
    localparam int N_OUT  = 3;
    localparam int N_IN   = 4;
    localparam int SEG_W  = $clog2(N_SEG);

    typedef enum logic [1:0] {
        IN_A = 2'd0,
        IN_B = 2'd1,
        IN_C = 2'd2,
        IN_N = 2'd3
    } src_e;

    typedef struct packed {
        src_e pos;
        src_e neg;
    } rails_t;

    function automatic logic is_virtual(input logic [3:0] code);
        return (code >= 4'd7) && (code <= 4'd12);
    endfunction

    // neutral-arm vector n (1..6) to rail sources
    function automatic rails_t short_rails(input logic [2:0] n);
        rails_t r;
        case (n)
            3'd1:    r = '{IN_A, IN_N};
            3'd2:    r = '{IN_N, IN_C};
            3'd3:    r = '{IN_B, IN_N};
            3'd4:    r = '{IN_N, IN_A};
            3'd5:    r = '{IN_C, IN_N};
            3'd6:    r = '{IN_N, IN_B};
            default: r = '{IN_A, IN_A};
        endcase
        return r;
    endfunction

    function automatic rails_t rect_rails(input logic [3:0] code, input logic second);
        rails_t     r;
        logic [2:0] k;
        logic [2:0] k_prev;
        k      = 3'(code - 4'd6);
        k_prev = (k == 3'd1) ? 3'd6 : k - 3'd1;
        case (code)
            4'd1:    r = '{IN_A, IN_B};
            4'd2:    r = '{IN_A, IN_C};
            4'd3:    r = '{IN_B, IN_C};
            4'd4:    r = '{IN_B, IN_A};
            4'd5:    r = '{IN_C, IN_A};
            4'd6:    r = '{IN_C, IN_B};
            4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12:
                     r = short_rails(second ? k : k_prev);
            default: r = '{IN_A, IN_A};
        endcase
        return r;
    endfunction

    // output-side active vector n (1..6): bit p set -> phase p on positive rail
    function automatic logic [2:0] inv_pattern(input logic [2:0] n);
        logic [2:0] pat;
        case (n)
            3'd1:    pat = 3'b001;
            3'd2:    pat = 3'b011;
            3'd3:    pat = 3'b010;
            3'd4:    pat = 3'b110;
            3'd5:    pat = 3'b100;
            3'd6:    pat = 3'b101;
            default: pat = 3'b001;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/mc_seq_timing.sv
`timescale 1ns/1ps
module mc_seq_timing
    import mc_seq_pkg::*;
#(
    parameter int PERIOD = 16666,
    parameter int DUTY_W = 16,
    parameter int CNT_W  = 15
) (
    input  logic [N_SLOT-1:0][3:0]       vec_code,
    input  logic [DUTY_W-1:0]            duty0,
    input  logic [DUTY_W-1:0]            duty1,
    input  logic [DUTY_W-1:0]            duty_g,
    input  logic [DUTY_W-1:0]            duty_d,
    output logic [N_SEG-1:0][CNT_W-1:0]  seg_end
);

    localparam int PW = DUTY_W + CNT_W + 1;
    localparam int GW = DUTY_W + 1;
    localparam int QW = 2 * DUTY_W;
    localparam int LW = CNT_W + GW + 1;
    localparam logic [PW-1:0]    P_RND = PW'(1) << (DUTY_W - 1);
    localparam logic [LW-1:0]    L_RND = LW'(1) << (DUTY_W - 1);
    localparam logic [CNT_W-1:0] P_CNT = CNT_W'(PERIOD);

    logic [PW-1:0]    prod0, prod1;
    logic [CNT_W-1:0] len0, len1_raw, len1, len2;
    logic [N_SLOT-1:0][CNT_W-1:0] slot_len;

    // slot lengths: rounded shares of the period, last slot takes the rest
    always_comb begin
        prod0    = PW'(duty0) * PW'(PERIOD) + P_RND;
        prod1    = PW'(duty1) * PW'(PERIOD) + P_RND;
        len0     = CNT_W'(prod0 >> DUTY_W);
        len1_raw = CNT_W'(prod1 >> DUTY_W);
        len1     = (len1_raw > (P_CNT - len0)) ? (P_CNT - len0) : len1_raw;
        len2     = P_CNT - len0 - len1;
        slot_len = {len2, len1, len0};
    end

    // renormalised first-vector ratio, fraction of 2^DUTY_W
    logic [GW-1:0] dsum;
    logic [QW-1:0] numer, quot;
    logic [GW-1:0] ratio;

    always_comb begin
        dsum  = GW'(duty_g) + GW'(duty_d);
        numer = {duty_g, {DUTY_W{1'b0}}};
        quot  = (dsum == '0) ? '0 : numer / QW'(dsum);
        if (dsum == '0)
            ratio = GW'(1) << (DUTY_W - 1);
        else if (quot > (QW'(1) << DUTY_W))
            ratio = GW'(1) << DUTY_W;
        else
            ratio = GW'(quot);
    end

    logic [N_SUB-1:0][CNT_W-1:0] sub_len;
    logic [N_SEG-1:0][CNT_W-1:0] seg_len;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        logic [CNT_W-1:0] head;
        assign head             = is_virtual(vec_code[s]) ? (slot_len[s] >> 1) : slot_len[s];
        assign sub_len[2*s]     = head;
        assign sub_len[2*s + 1] = slot_len[s] - head;
    end

    for (genvar j = 0; j < N_SUB; j++) begin : g_sub
        logic [LW-1:0]    scaled;
        logic [CNT_W-1:0] first_len;
        assign scaled    = LW'(sub_len[j]) * LW'(ratio) + L_RND;
        assign first_len = CNT_W'(scaled >> DUTY_W);
        if (j % 2 == 0) begin : g_fwd
            assign seg_len[2*j]     = first_len;
            assign seg_len[2*j + 1] = sub_len[j] - first_len;
        end else begin : g_rev
            assign seg_len[2*j]     = sub_len[j] - first_len;
            assign seg_len[2*j + 1] = first_len;
        end
    end

    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int m = 0; m < N_SEG; m++) begin
            acc        = acc + seg_len[m];
            seg_end[m] = acc;
        end
    end

endmodule

// File: rtl/mc_seq_decode.sv
`timescale 1ns/1ps
module mc_seq_decode
    import mc_seq_pkg::*;
(
    input  logic [N_SLOT-1:0][3:0]   vec_code,
    input  logic [2:0]               sector,
    input  logic [SEG_W-1:0]         seg,
    output logic [N_OUT*N_IN-1:0]    sw
);

    logic [2:0] sub;
    logic [3:0] code;
    logic       use_second;
    rails_t     rl;
    logic [2:0] g_n, d_n, pat;
    src_e       src;

    always_comb begin
        sub        = seg[SEG_W-1:1];
        use_second = sub[0] ^ seg[0];
        case (sub[2:1])
            2'd1:    code = vec_code[1];
            2'd2:    code = vec_code[2];
            default: code = vec_code[0];
        endcase
        rl  = rect_rails(code, sub[0]);
        g_n = sector + 3'd1;
        d_n = (sector == 3'd5) ? 3'd1 : sector + 3'd2;
        pat = use_second ? inv_pattern(d_n) : inv_pattern(g_n);
        sw  = '0;
        for (int p = 0; p < N_OUT; p++) begin
            src = pat[p] ? rl.pos : rl.neg;
            sw[p*N_IN + int'(src)] = 1'b1;
        end
    end

endmodule

// File: rtl/mc_seq_phase_check.sv
`timescale 1ns/1ps
module mc_seq_phase_check
    import mc_seq_pkg::*;
(
    input  logic [N_OUT*N_IN-1:0] sw,
    output logic                  fault
);

    logic [N_OUT-1:0] bad;

    for (genvar p = 0; p < N_OUT; p++) begin : g_phase
        logic [N_IN-1:0] row;
        assign row    = sw[p*N_IN +: N_IN];
        assign bad[p] = (row == '0) || ((row & (row - 1'b1)) != '0);
    end

    assign fault = |bad;

endmodule

// File: rtl/mc_switch_sequencer.sv
`timescale 1ns/1ps
module mc_switch_sequencer
    import mc_seq_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int SW_HZ  = 6_000,
    parameter int DUTY_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [3:0]             vec0,
    input  logic [3:0]             vec1,
    input  logic [3:0]             vec2,
    input  logic [DUTY_W-1:0]      duty0,
    input  logic [DUTY_W-1:0]      duty1,
    input  logic [2:0]             inv_sector,
    input  logic [DUTY_W-1:0]      duty_g,
    input  logic [DUTY_W-1:0]      duty_d,
    output logic [N_OUT*N_IN-1:0]  sw,
    output logic                   phase_fault
);

    localparam int PERIOD = CLK_HZ / SW_HZ;
    localparam int CNT_W  = $clog2(PERIOD + 1);
    localparam logic [CNT_W-1:0]        LAST_T  = CNT_W'(PERIOD - 1);
    localparam logic [N_OUT*N_IN-1:0]   IDLE_SW = 12'h111;

    typedef struct packed {
        logic                        running;
        logic [CNT_W-1:0]            t;
        logic [N_SLOT-1:0][3:0]      codes;
        logic [2:0]                  sector;
        logic [N_SEG-1:0][CNT_W-1:0] ends;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [N_SLOT-1:0][3:0]      in_codes;
    logic [N_SEG-1:0][CNT_W-1:0] new_ends;
    logic [SEG_W-1:0]            seg;
    logic [N_OUT*N_IN-1:0]       dec_sw;
    logic [CNT_W-1:0]            t_q;
    logic                        running_q;

    assign in_codes  = {vec2, vec1, vec0};
    assign t_q       = state_q.t;
    assign running_q = state_q.running;

    mc_seq_timing #(
        .PERIOD (PERIOD),
        .DUTY_W (DUTY_W),
        .CNT_W  (CNT_W)
    ) u_timing (
        .vec_code (in_codes),
        .duty0    (duty0),
        .duty1    (duty1),
        .duty_g   (duty_g),
        .duty_d   (duty_d),
        .seg_end  (new_ends)
    );

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d.running = 1'b1;
            state_d.t       = '0;
            state_d.codes   = in_codes;
            state_d.sector  = (inv_sector > 3'd5) ? 3'd0 : inv_sector;
            state_d.ends    = new_ends;
        end else if (state_q.running) begin
            state_d.t = (state_q.t == LAST_T) ? '0 : state_q.t + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // earliest interval whose end lies beyond the current cycle
    always_comb begin
        seg = SEG_W'(N_SEG - 1);
        for (int m = N_SEG - 1; m >= 0; m--) begin
            if (state_q.t < state_q.ends[m]) seg = SEG_W'(m);
        end
    end

    mc_seq_decode u_decode (
        .vec_code (state_q.codes),
        .sector   (state_q.sector),
        .seg      (seg),
        .sw       (dec_sw)
    );

    assign sw = state_q.running ? dec_sw : IDLE_SW;

    mc_seq_phase_check u_check (
        .sw    (sw),
        .fault (phase_fault)
    );

endmodule

// File: rtl/mc_switch_sequencer_chk.sv
`timescale 1ns/1ps
module mc_switch_sequencer_chk #(
    parameter int PERIOD = 16666,
    parameter int CNT_W  = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [11:0]      sw,
    input logic             phase_fault,
    input logic [CNT_W-1:0] t_q,
    input logic             running_q
);

    a_r2_one_switch_per_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sw[3:0]) == 1) && ($countones(sw[7:4]) == 1) && ($countones(sw[11:8]) == 1));

    a_r10_fault_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        phase_fault == (($countones(sw[3:0]) != 1) || ($countones(sw[7:4]) != 1) ||
                        ($countones(sw[11:8]) != 1)));

    a_r1_idle_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        !running_q |-> (sw == 12'h111));

    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running_q && (t_q == '0)));

    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !start && (t_q == CNT_W'(PERIOD - 1))) |=> (t_q == '0));

    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !start && (t_q != CNT_W'(PERIOD - 1))) |=> (t_q == $past(t_q) + 1'b1));

    a_r3_cycle_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        t_q < CNT_W'(PERIOD));

endmodule

bind mc_switch_sequencer mc_switch_sequencer_chk #(
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sw          (sw),
    .phase_fault (phase_fault),
    .t_q         (t_q),
    .running_q   (running_q)
);

// File: tb/mc_switch_sequencer_test.sv
`timescale 1ns/1ps
module mc_switch_sequencer_test;

    localparam int CLK_HZ = 600_000;
    localparam int SW_HZ  = 6_000;
    localparam int P      = CLK_HZ / SW_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  vec0 = '0, vec1 = '0, vec2 = '0;
    logic [15:0] duty0 = '0, duty1 = '0, duty_g = '0, duty_d = '0;
    logic [2:0]  inv_sector = '0;
    logic [11:0] sw;
    logic        phase_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int exp_sw [P];

    always #5 clk = ~clk;

    mc_switch_sequencer #(
        .CLK_HZ (CLK_HZ),
        .SW_HZ  (SW_HZ),
        .DUTY_W (16)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .vec0        (vec0),
        .vec1        (vec1),
        .vec2        (vec2),
        .duty0       (duty0),
        .duty1       (duty1),
        .inv_sector  (inv_sector),
        .duty_g      (duty_g),
        .duty_d      (duty_d),
        .sw          (sw),
        .phase_fault (phase_fault)
    );

    // rail sources per rectifier code (R4, R5): 0=A 1=B 2=C 3=N
    task automatic ref_rails(input int code, input int second, output int p, output int n);
        int k;
        p = 0; n = 0;
        if (code >= 7 && code <= 12) begin
            k = code - 6;
            if (second == 0) k = (k == 1) ? 6 : k - 1;
            case (k)
                1: begin p = 0; n = 3; end
                2: begin p = 3; n = 2; end
                3: begin p = 1; n = 3; end
                4: begin p = 3; n = 0; end
                5: begin p = 2; n = 3; end
                default: begin p = 3; n = 1; end
            endcase
        end else begin
            case (code)
                1: begin p = 0; n = 1; end
                2: begin p = 0; n = 2; end
                3: begin p = 1; n = 2; end
                4: begin p = 1; n = 0; end
                5: begin p = 2; n = 0; end
                6: begin p = 2; n = 1; end
                default: begin p = 0; n = 0; end
            endcase
        end
    endtask

    // R6: phases on the positive rail for active vector v
    function automatic bit on_pos(input int v, input int ph);
        case (v)
            1: return ph == 0;
            2: return ph == 0 || ph == 1;
            3: return ph == 1;
            4: return ph == 1 || ph == 2;
            5: return ph == 2;
            default: return ph == 0 || ph == 2;
        endcase
    endfunction

    task automatic build(input int c0, input int c1, input int c2, input int d0, input int d1,
                         input int sec, input int dg, input int dd);
        longint l0, l1, ratio, sum;
        int slot_len [3];
        int codes [3];
        int gv, dv, idx;
        codes[0] = c0; codes[1] = c1; codes[2] = c2;
        if (sec > 5) sec = 0;
        gv = sec + 1;
        dv = (gv == 6) ? 1 : gv + 1;
        l0 = (longint'(d0) * P + 32768) >> 16;
        l1 = (longint'(d1) * P + 32768) >> 16;
        if (l1 > P - l0) l1 = P - l0;
        slot_len[0] = int'(l0);
        slot_len[1] = int'(l1);
        slot_len[2] = P - int'(l0) - int'(l1);
        sum   = longint'(dg) + longint'(dd);
        ratio = (sum == 0) ? 32768 : ((longint'(dg) << 16) / sum);
        idx = 0;
        for (int j = 0; j < 6; j++) begin
            int s, code, len_sub, head, gl;
            bit virt;
            s    = j / 2;
            code = codes[s];
            virt = (code >= 7 && code <= 12);
            head = virt ? slot_len[s] / 2 : slot_len[s];
            len_sub = (j % 2 == 0) ? head : slot_len[s] - head;
            gl = int'((longint'(len_sub) * ratio + 32768) >> 16);
            for (int q = 0; q < 2; q++) begin
                bit first_vec;
                int len, pr, nr, word;
                first_vec = ((j % 2 == 0) == (q == 0));
                len = first_vec ? gl : len_sub - gl;
                ref_rails(code, j % 2, pr, nr);
                word = 0;
                for (int ph = 0; ph < 3; ph++)
                    word |= 1 << (ph * 4 + (on_pos(first_vec ? gv : dv, ph) ? pr : nr));
                for (int c = 0; c < len; c++) begin
                    if (idx < P) exp_sw[idx] = word;
                    idx++;
                end
            end
        end
    endtask

    task automatic check_cycle(input int expv, input string tag);
        int ones;
        n_checks++;
        if (sw !== 12'(expv)) begin
            n_fail++;
            $display("FAIL %s: sw actual %03h expected %03h", tag, sw, 12'(expv));
        end
        n_checks++;
        if (phase_fault !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: phase_fault actual %0b expected 0", phase_fault);
        end
        for (int ph = 0; ph < 3; ph++) begin
            ones = $countones(sw[ph*4 +: 4]);
            n_checks++;
            if (ones != 1) begin
                n_fail++;
                $display("FAIL R2: phase %0d closed switches actual %0d expected 1", ph, ones);
            end
        end
    endtask

    task automatic run(input int c0, input int c1, input int c2, input int d0, input int d1,
                       input int sec, input int dg, input int dd, input int ncyc, input string tag);
        @(negedge clk);
        vec0 = 4'(c0); vec1 = 4'(c1); vec2 = 4'(c2);
        duty0 = 16'(d0); duty1 = 16'(d1);
        inv_sector = 3'(sec); duty_g = 16'(dg); duty_d = 16'(dd);
        start = 1'b1;
        build(c0, c1, c2, d0, d1, sec, dg, dd);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            check_cycle(exp_sw[c % P], tag);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check_cycle(12'h111, "R1");
        end
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check_cycle(12'h111, "R1");
        end
        // R3 R5 R6 R7: line vectors and null vector, two full periods (R9 repeat)
        run(1, 2, 0, 26214, 22938, 0, 30000, 20000, 2 * P, "R3");
        // R4: virtual vectors split into halves
        run(7, 3, 8, 20000, 25000, 2, 40000, 10000, P, "R4");
        // R8: all slots virtual, alternating order, lopsided ratio
        run(9, 10, 11, 13107, 30000, 4, 60000, 3000, P, "R8");
        run(12, 7, 10, 40000, 5000, 3, 1000, 50000, P, "R8");
        // R6 R5: sector 6 treated as 0, code 13 as null vector
        run(13, 4, 12, 20000, 20000, 6, 35000, 25000, P, "R6");
        // R7: both active duties zero -> even split
        run(5, 6, 0, 30000, 30000, 5, 0, 0, P, "R7");
        // R3: duties summing over one period clip slot 1
        run(1, 9, 3, 50000, 40000, 1, 30000, 30000, P, "R3");
        // R9: restart mid-period with a new set
        run(2, 11, 4, 21845, 21845, 3, 20000, 44000, 37, "R9");
        run(8, 8, 8, 10000, 50000, 0, 32768, 32768, P + 10, "R9");
        // R5 R6: sweep of all sectors with each virtual code
        for (int s = 0; s < 6; s++)
            run(7 + s, 1 + s, 7 + ((s + 3) % 6), 18000 + 1000 * s, 24000, s,
                15000 + 7000 * s, 52000 - 6000 * s, P, "R5");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9: watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule